// File: doc/BRIEF.md
# IO-Mapped Latched Tick Timer

This peripheral sits on an 8-bit IO bus and counts IO-bus clock ticks in a 32-bit free-running counter. Software uses it to time a stretch of code. It first writes to the base port to zero the counter. It runs the code under test. It then reads the base port and the three ports above it to collect the elapsed tick count.

The counter advances once for every cycle in which the count-enable tick is high. At the IO-bus rate of 3.5 MHz, this gives one count per bus clock. A read of the base port copies the whole count into a holding register and returns the lowest byte. Reads of base+1 to base+3 return the higher bytes of that held copy. The CPU therefore assembles a consistent 32-bit sample, even while the counter keeps running between its byte reads.

Read data is produced combinationally during the read strobe, with an output enable. The block decodes the port address itself. It has no write-data input, because any written value has the same effect.

Top module: `io_tick_timer`

## Requirements
- R1: The counter increases by exactly one on each clock cycle in which `cnt_tick` is high, and holds its value in cycles where it is low.
- R2: A write strobe to the base port (0x20) clears the counter to zero.
- R3: When a base-port write and a tick occur in the same cycle, the counter becomes zero; the clear takes precedence.
- R4: The counter wraps from all-ones to zero and keeps counting, with no other visible effect.
- R5: During a read strobe on port 0x20, `io_dout` carries bits 7:0 of the count as it stood before any increment in that cycle. The same count is copied into the holding register at the end of that cycle.
- R6: Reads of ports 0x21, 0x22 and 0x23 return bits 15:8, 23:16 and 31:24 of the holding register.
- R7: Reads of ports 0x21 to 0x23 never change the holding register. A later read of an upper port returns the same byte even though the counter has moved on.
- R8: `io_dout_en` is high only while `io_rd` is high with an address in 0x20 to 0x23. Whenever `io_dout_en` is low, `io_dout` is 0x00.
- R9: Writes to any port other than 0x20, including 0x21 to 0x23, leave the counter unaffected.
- R10: After reset, the counter and the holding register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | IO port address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| cnt_tick | input | 1 | Count enable, high once per IO-bus clock |
| io_dout | output | 8 | Read data, zero when not enabled |
| io_dout_en | output | 1 | Read data valid / drive enable |

## Verification
A read strobe is swept across all 256 addresses while the tick toggles in an irregular pattern. This separates the four decoded ports from every alias and neighbour, and it shows whether the base-port byte is the live count taken before the same-cycle increment. A write strobe is swept across every non-base port under continuous ticking, which would expose any stray clear. Upper-port reads are repeated after more ticks, which tells a held snapshot apart from a live counter. A narrow 16-bit instance is driven through its full range to observe the wrap, and a clear coinciding with a tick shows which of the two wins.

// File: rtl/iotmr_pkg.sv
package iotmr_pkg;
    localparam int              ADDR_W_DEF = 8;
    localparam int              DATA_W_DEF = 8;
    localparam int              CNT_W_DEF  = 32;
    localparam logic [7:0]      BASE_DEF   = 8'h20;
endpackage

// File: rtl/iotmr_decode.sv
// Port decoder: base must be aligned to the number of byte lanes.
module iotmr_decode #(
    parameter int                ADDR_W    = 8,
    parameter int                SEL_W     = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              rd_hit,
    output logic [SEL_W-1:0]  lane,
    output logic              clr,
    output logic              cap
);
    logic hit;

    always_comb begin
        hit    = (addr[ADDR_W-1:SEL_W] == BASE_ADDR[ADDR_W-1:SEL_W]);
        lane   = addr[SEL_W-1:0];
        rd_hit = rd && hit;
        clr    = wr && hit && (lane == '0);
        cap    = rd_hit && (lane == '0);
    end
endmodule

// File: rtl/iotmr_counter.sv
module iotmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> (cnt == $past(cnt) + CNT_W'(1)));
    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt));
    a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/iotmr_snapshot.sv
// Holds only the upper bytes: lane 0 is served from the live count.
module iotmr_snapshot #(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              rd_hit,
    input  logic [SEL_W-1:0]  lane,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] dout,
    output logic              oe
);
    localparam int LANES  = CNT_W / DATA_W;
    localparam int HOLD_W = CNT_W - DATA_W;

    typedef struct packed {
        logic [HOLD_W-1:0] hold;
    } snap_st_t;

    snap_st_t st_d, st_q;
    logic [DATA_W-1:0] lane_byte [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_live
            assign lane_byte[g] = cnt[DATA_W-1:0];
        end else begin : g_held
            assign lane_byte[g] = st_q.hold[(g-1)*DATA_W +: DATA_W];
        end
    end

    always_comb begin
        st_d = st_q;
        if (cap) begin
            st_d.hold = cnt[CNT_W-1:DATA_W];
        end
        oe   = rd_hit;
        dout = rd_hit ? lane_byte[lane] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (st_q.hold == $past(cnt[CNT_W-1:DATA_W])));
    a_r7_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(st_q.hold));
endmodule

// File: rtl/io_tick_timer.sv
module io_tick_timer #(
    parameter int                ADDR_W    = iotmr_pkg::ADDR_W_DEF,
    parameter int                DATA_W    = iotmr_pkg::DATA_W_DEF,
    parameter int                CNT_W     = iotmr_pkg::CNT_W_DEF,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(iotmr_pkg::BASE_DEF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              cnt_tick,
    output logic [DATA_W-1:0] io_dout,
    output logic              io_dout_en
);
    localparam int LANES = CNT_W / DATA_W;
    localparam int SEL_W = $clog2(LANES);

    logic             rd_hit;
    logic [SEL_W-1:0] lane;
    logic             clr;
    logic             cap;
    logic [CNT_W-1:0] cnt;

    iotmr_decode #(
        .ADDR_W    (ADDR_W),
        .SEL_W     (SEL_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr   (io_addr),
        .rd     (io_rd),
        .wr     (io_wr),
        .rd_hit (rd_hit),
        .lane   (lane),
        .clr    (clr),
        .cap    (cap)
    );

    iotmr_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (cnt_tick),
        .clr   (clr),
        .cnt   (cnt)
    );

    iotmr_snapshot #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) u_snapshot (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap),
        .rd_hit (rd_hit),
        .lane   (lane),
        .cnt    (cnt),
        .dout   (io_dout),
        .oe     (io_dout_en)
    );

    a_r8_enable_range: assert property (@(posedge clk) disable iff (!rst_n)
        io_dout_en |-> (io_rd && (io_addr >= BASE_ADDR)
                        && (io_addr < BASE_ADDR + ADDR_W'(LANES))));
    a_r8_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !io_dout_en |-> (io_dout == '0));
    a_r9_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !cnt_tick && (io_addr != BASE_ADDR)) |=> $stable(cnt));
endmodule

// File: tb/io_tick_timer_bench.sv
module io_tick_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       io_rd = 1'b0;
    logic       io_wr = 1'b0;
    logic       cnt_tick = 1'b0;
    logic [7:0] io_dout;
    logic       io_dout_en;

    logic [7:0] n_addr = 8'h00;
    logic       n_rd = 1'b0;
    logic       n_wr = 1'b0;
    logic       n_tick = 1'b0;
    logic [7:0] n_dout;
    logic       n_dout_en;

    int tests = 0;
    int fails = 0;

    logic [31:0] mdl_cnt  = '0;
    logic [31:0] mdl_hold = '0;

    always #4 clk = ~clk;

    io_tick_timer u_io_tick_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_addr    (io_addr),
        .io_rd      (io_rd),
        .io_wr      (io_wr),
        .cnt_tick   (cnt_tick),
        .io_dout    (io_dout),
        .io_dout_en (io_dout_en)
    );

    io_tick_timer #(.CNT_W(16)) u_io_tick_timer_w16 (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_addr    (n_addr),
        .io_rd      (n_rd),
        .io_wr      (n_wr),
        .cnt_tick   (n_tick),
        .io_dout    (n_dout),
        .io_dout_en (n_dout_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One bus cycle on the 32-bit instance, checked against the requirement model.
    task automatic step(input logic rd, input logic wr, input logic [7:0] a,
                        input logic tk, input string tag);
        logic       exp_en;
        logic [7:0] exp_d;
        io_rd = rd; io_wr = wr; io_addr = a; cnt_tick = tk;
        #1;
        exp_en = rd && (a >= 8'h20) && (a <= 8'h23);
        if (!exp_en)          exp_d = 8'h00;
        else if (a == 8'h20)  exp_d = mdl_cnt[7:0];
        else                  exp_d = mdl_hold[(a - 8'h20) * 8 +: 8];
        check({tag, " enable"}, 32'(io_dout_en), 32'(exp_en));
        check({tag, " data"}, 32'(io_dout), 32'(exp_d));
        @(posedge clk);
        if (rd && a == 8'h20) mdl_hold = mdl_cnt;
        if (wr && a == 8'h20) mdl_cnt = '0;
        else if (tk)          mdl_cnt = mdl_cnt + 32'd1;
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0; cnt_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 1'b1, "R1");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state, all four bytes zero
        step(1'b1, 1'b0, 8'h20, 1'b0, "R10");
        for (int p = 1; p < 4; p++) step(1'b1, 1'b0, 8'(8'h20 + p), 1'b0, "R10");

        // R1 / R5: counting and base read
        ticks(20);
        step(1'b1, 1'b0, 8'h20, 1'b0, "R5");
        ticks(300);
        step(1'b1, 1'b0, 8'h20, 1'b0, "R5");
        step(1'b1, 1'b0, 8'h21, 1'b0, "R6");
        step(1'b1, 1'b0, 8'h22, 1'b1, "R6");
        // R7: upper reads keep the snapshot while the counter moves
        ticks(700);
        step(1'b1, 1'b0, 8'h21, 1'b1, "R7");
        step(1'b1, 1'b0, 8'h23, 1'b0, "R7");
        // R5: read with tick in same cycle returns pre-increment value
        step(1'b1, 1'b0, 8'h20, 1'b1, "R5");
        step(1'b1, 1'b0, 8'h21, 1'b0, "R6");

        // R8: read sweep over every address with an irregular tick pattern
        for (int a = 0; a < 256; a++) step(1'b1, 1'b0, 8'(a), (a % 3) != 0, "R8");
        for (int p = 1; p < 4; p++) step(1'b1, 1'b0, 8'(8'h20 + p), 1'b0, "R6");

        // R9: writes to every other port leave the counter alone
        for (int a = 0; a < 256; a++)
            if (a != 32'h20) step(1'b0, 1'b1, 8'(a), 1'b1, "R9");
        step(1'b1, 1'b0, 8'h20, 1'b0, "R9");
        step(1'b1, 1'b0, 8'h21, 1'b0, "R9");

        // R2: clear without tick
        step(1'b0, 1'b1, 8'h20, 1'b0, "R2");
        step(1'b1, 1'b0, 8'h20, 1'b0, "R2");
        check("R2 model zero", mdl_hold, 32'd0);
        // R3: clear and tick together
        ticks(5);
        step(1'b0, 1'b1, 8'h20, 1'b1, "R3");
        step(1'b1, 1'b0, 8'h20, 1'b0, "R3");
        step(1'b1, 1'b0, 8'h21, 1'b0, "R3");

        // R4: wrap on the 16-bit instance
        n_tick = 1'b1;
        repeat (65535) @(negedge clk);
        n_tick = 1'b0; n_rd = 1'b1; n_addr = 8'h20;
        #1;
        check("R4 low byte at max", 32'(n_dout), 32'h0000_00ff);
        check("R4 enable", 32'(n_dout_en), 32'd1);
        @(negedge clk);
        n_addr = 8'h21;
        #1;
        check("R4 high byte at max", 32'(n_dout), 32'h0000_00ff);
        @(negedge clk);
        n_rd = 1'b0; n_tick = 1'b1;
        @(negedge clk);
        n_tick = 1'b0; n_rd = 1'b1; n_addr = 8'h20;
        #1;
        check("R4 low byte after wrap", 32'(n_dout), 32'h0);
        @(negedge clk);
        n_addr = 8'h21;
        #1;
        check("R4 high byte after wrap", 32'(n_dout), 32'h0);
        @(negedge clk);
        n_rd = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule